// File: doc/BRIEF.md
# Sampling-Phase Margin Sweep and Selector

This block closes out receiver training. At each candidate sampling phase it takes over the comparator offset DAC, starts at the top code, and counts detected bit errors over one full training-pattern period. If any error is seen, it lowers the offset code by one and measures again. The first code that gives an error-free pattern period is the voltage margin for that phase. If the offset reaches zero and errors remain, the phase is recorded with margin zero and the error count from that last window. Each phase is logged in a small table that holds the phase code, the margin and the error count.

After the last phase in the range it scans the table twice. The first pass finds the best entry, which is the largest margin and then the fewest errors. The second pass finds the first contiguous run of phases that tie with that entry. The block settles on the centre of that run, releases the offset override and raises `done`. From then on it ignores the error stream, so every setting stays frozen until the next start. A start with the abbreviated flag set sweeps only a small window of phases around the phase chosen last time. This is the quick retune used after environmental drift.

Top module: `margin_phase_sweep`

## Requirements
- R1: While reset is high and after it, until the first start, `done` and `ofs_force` are 0 and `phase_code` is 0.
- R2: A `start` pulse while idle begins a sweep on the next clock. `phase_code` becomes the first phase of the range, `ofs_code` becomes the all-ones maximum, `ofs_force` rises and `done` falls.
- R3: A measurement window is WIN accepted bits, where a bit is accepted when `bit_valid` is 1. A window with zero errors records the current `ofs_code` as the margin, with error count 0. A window with any error lowers `ofs_code` by one and opens a new window. Within one phase the offset never rises.
- R4: If the window at offset code 0 still has errors, the block records margin 0 and that window's error count. The count saturates at 2^ERR_W-1.
- R5: `rd_data` shows the table entry at `rd_addr` one clock after the address is presented. Bits [ERR_W-1:0] hold the error count, the next OFS_W bits hold the margin, and the top PH_W bits hold the phase code.
- R6: After a phase is recorded, the sweep moves to the next phase (phase+1) and reloads the maximum offset, until the last phase of the range.
- R7: The chosen phase has the largest recorded margin in the range. Among equal margins it has the fewest errors.
- R8: If several phases share the best margin and error count, the chosen phase is the centre of the first contiguous run of them. For an even-length run it is the lower of the two middle phases.
- R9: When selection ends, `phase_code` holds the chosen phase, `done` is 1 and `ofs_force` is 0. While done, `bit_valid`/`err_bit` change no output and no table entry.
- R10: With `abbrev` high at start, the range is [max(prev-ABBR_HALF,0), min(prev+ABBR_HALF,NPH-1)], where prev is the current `phase_code`. Entries outside the range keep their values, and selection considers only the range. With `abbrev` low, the range is every phase.
- R11: A `start` pulse during a sweep or a selection scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (taken only when idle) |
| abbrev | input | 1 | Sampled with start: sweep only around the previous phase |
| bit_valid | input | 1 | One received training bit compared this cycle |
| err_bit | input | 1 | That bit mismatched the expected pattern |
| rd_addr | input | PH_W | Table readout address |
| phase_code | output | PH_W | Sampling phase driven to the interpolator |
| ofs_code | output | OFS_W | Offset DAC code override value |
| ofs_force | output | 1 | Offset override active |
| rd_data | output | PH_W+OFS_W+ERR_W | Table entry, one clock after rd_addr |
| done | output | 1 | Selection finished, settings frozen |

## Verification
The properties assume that the error stream reflects the offset and phase currently driven. They also assume that the outside world restarts its notion of a pattern window whenever those settings change. The bench honours this by tracking the settings at the ports and realigning its per-window bit index on every change. The bench's error model is monotone in offset: errors appear above a per-phase threshold, or at every code for phases marked bad. This mirrors a real eye, and because of it the first error-free code is well defined. `bit_valid` is dropped at random, and `start` is pulsed mid-sweep and the error inputs are randomised while done. This exercises the ignore rules without ever violating the window alignment the checks depend on.

// File: rtl/nm_pkg.sv
package nm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_BEST = 2'd2,
    ST_RUN  = 2'd3
  } nm_state_t;
endpackage

// File: rtl/nm_window.sv
// Counts accepted bits and saturating errors over one pattern period.
module nm_window #(
  parameter int WIN   = 128,
  parameter int ERR_W = 8,
  localparam int CNT_W = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_valid,
  input  logic             err_bit,
  output logic             win_end,
  output logic [ERR_W-1:0] win_errs
);
  localparam logic [ERR_W-1:0] ERR_SAT = '1;
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(WIN - 1);

  logic [CNT_W-1:0] cnt;
  logic [ERR_W-1:0] errs;

  // total including the bit presented this cycle
  always_comb begin
    if (err_bit && errs != ERR_SAT) win_errs = errs + 1'b1;
    else                            win_errs = errs;
  end

  assign win_end = bit_valid && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      errs <= '0;
    end else if (bit_valid) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        errs <= '0;
      end else begin
        cnt  <= cnt + 1'b1;
        errs <= win_errs;
      end
    end
  end
endmodule

// File: rtl/nm_table.sv
// Simple dual-port table: one write port, one registered read port.
module nm_table #(
  parameter int AW = 6,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/margin_phase_sweep.sv
module margin_phase_sweep
  import nm_pkg::*;
#(
  parameter int NPH       = 64,
  parameter int OFS_W     = 10,
  parameter int ERR_W     = 8,
  parameter int WIN       = 128,
  parameter int ABBR_HALF = 4,
  localparam int PH_W  = $clog2(NPH),
  localparam int ENT_W = PH_W + OFS_W + ERR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abbrev,
  input  logic             bit_valid,
  input  logic             err_bit,
  input  logic [PH_W-1:0]  rd_addr,
  output logic [PH_W-1:0]  phase_code,
  output logic [OFS_W-1:0] ofs_code,
  output logic             ofs_force,
  output logic [ENT_W-1:0] rd_data,
  output logic             done
);
  localparam logic [OFS_W-1:0] OFS_MAX = '1;

  nm_state_t        state;
  logic [PH_W-1:0]  phase_r, lo_r, hi_r, lo_n, hi_n;
  logic [PH_W-1:0]  scan_a, q_idx, run_s, pick_r;
  logic [OFS_W-1:0] ofs_r, best_m;
  logic [ERR_W-1:0] best_e;
  logic             force_r, done_r, iss, q_vld, have, in_run, found;

  // measurement window
  logic             win_end;
  logic [ERR_W-1:0] win_errs;

  nm_window #(.WIN(WIN), .ERR_W(ERR_W)) u_win (
    .clk(clk), .rst(rst), .clr(state != ST_MEAS),
    .bit_valid(bit_valid), .err_bit(err_bit),
    .win_end(win_end), .win_errs(win_errs)
  );

  // R3/R4: a phase is recorded on a clean window or when the offset is exhausted
  logic             rec;
  logic             tbl_we;
  logic [ENT_W-1:0] tbl_wd;
  logic [PH_W-1:0]  tbl_ra;

  assign rec    = win_end && ((win_errs == '0) || (ofs_r == '0));
  assign tbl_we = (state == ST_MEAS) && rec;
  assign tbl_wd = {phase_r, (win_errs == '0) ? ofs_r : {OFS_W{1'b0}}, win_errs};
  assign tbl_ra = (state == ST_BEST || state == ST_RUN) ? scan_a : rd_addr;

  nm_table #(.AW(PH_W), .DW(ENT_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(phase_r), .wdata(tbl_wd),
    .raddr(tbl_ra), .rdata(rd_data)
  );

  // R10: sweep range around the held phase, clamped to the table
  always_comb begin
    int c, l, h;
    c = int'(phase_r);
    l = abbrev ? c - ABBR_HALF : 0;
    h = abbrev ? c + ABBR_HALF : NPH - 1;
    if (l < 0)       l = 0;
    if (h > NPH - 1) h = NPH - 1;
    lo_n = PH_W'(l);
    hi_n = PH_W'(h);
  end

  // entry fields from the read port
  logic [ERR_W-1:0] ent_e;
  logic [OFS_W-1:0] ent_m;
  logic             better, key_eq;
  assign ent_e  = rd_data[ERR_W-1:0];
  assign ent_m  = rd_data[ERR_W +: OFS_W];
  // R7: larger margin first, then fewer errors
  assign better = !have || (ent_m > best_m) || ((ent_m == best_m) && (ent_e < best_e));
  assign key_eq = (ent_m == best_m) && (ent_e == best_e);

  function automatic logic [PH_W-1:0] mid(input logic [PH_W-1:0] a, input logic [PH_W-1:0] b);
    return a + ((b - a) >> 1);
  endfunction

  // R8: centre of the first run of entries equal to the best key
  logic            nx_in, nx_found;
  logic [PH_W-1:0] nx_s, nx_pick;
  always_comb begin
    nx_in    = in_run;
    nx_s     = run_s;
    nx_found = found;
    nx_pick  = pick_r;
    if (!found) begin
      if (key_eq) begin
        if (!in_run) begin
          nx_in = 1'b1;
          nx_s  = q_idx;
        end
        if (q_idx == hi_r) begin
          nx_found = 1'b1;
          nx_pick  = mid(nx_s, q_idx);
        end
      end else if (in_run) begin
        nx_found = 1'b1;
        nx_pick  = mid(run_s, q_idx - 1'b1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase_r <= '0;
      ofs_r   <= '0;
      force_r <= 1'b0;
      done_r  <= 1'b0;
      lo_r    <= '0;
      hi_r    <= '0;
      scan_a  <= '0;
      q_idx   <= '0;
      q_vld   <= 1'b0;
      iss     <= 1'b0;
      have    <= 1'b0;
      best_m  <= '0;
      best_e  <= '0;
      in_run  <= 1'b0;
      found   <= 1'b0;
      run_s   <= '0;
      pick_r  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin                     // R2, R11: start honoured only here
          lo_r    <= lo_n;
          hi_r    <= hi_n;
          phase_r <= lo_n;
          ofs_r   <= OFS_MAX;
          force_r <= 1'b1;
          done_r  <= 1'b0;
          state   <= ST_MEAS;
        end
        ST_MEAS: if (win_end) begin
          if (rec) begin
            if (phase_r == hi_r) begin
              force_r <= 1'b0;
              scan_a  <= lo_r;
              iss     <= 1'b1;
              q_vld   <= 1'b0;
              have    <= 1'b0;
              state   <= ST_BEST;
            end else begin                            // R6
              phase_r <= phase_r + 1'b1;
              ofs_r   <= OFS_MAX;
            end
          end else begin
            ofs_r <= ofs_r - 1'b1;                    // R3
          end
        end
        default: begin                                // ST_BEST / ST_RUN scans
          q_vld <= iss;
          q_idx <= scan_a;
          if (iss) begin
            if (scan_a == hi_r) iss <= 1'b0;
            else                scan_a <= scan_a + 1'b1;
          end
          if (q_vld) begin
            if (state == ST_BEST) begin
              if (better) begin
                have   <= 1'b1;
                best_m <= ent_m;
                best_e <= ent_e;
              end
              if (q_idx == hi_r) begin
                scan_a <= lo_r;
                iss    <= 1'b1;
                q_vld  <= 1'b0;
                in_run <= 1'b0;
                found  <= 1'b0;
                state  <= ST_RUN;
              end
            end else begin
              in_run <= nx_in;
              run_s  <= nx_s;
              found  <= nx_found;
              pick_r <= nx_pick;
              if (q_idx == hi_r) begin                // R9
                phase_r <= nx_pick;
                done_r  <= 1'b1;
                state   <= ST_IDLE;
              end
            end
          end
        end
      endcase
    end
  end

  assign phase_code = phase_r;
  assign ofs_code   = ofs_r;
  assign ofs_force  = force_r;
  assign done       = done_r;

  // ---------------- assertions ----------------
  a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
    $rose(ofs_force) |-> (ofs_code == OFS_MAX) && !done);

  a_r3_ofs_down: assert property (@(posedge clk) disable iff (rst)
    ofs_force && $past(ofs_force) && (phase_code == $past(phase_code))
      |-> ofs_code <= $past(ofs_code));

  a_r6_phase_step: assert property (@(posedge clk) disable iff (rst)
    ofs_force && $past(ofs_force) && (phase_code != $past(phase_code))
      |-> (phase_code == $past(phase_code) + 1'b1) && (ofs_code == OFS_MAX));

  a_r9_released: assert property (@(posedge clk) disable iff (rst)
    done |-> !ofs_force);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    done && $past(done) |-> $stable(phase_code) && $stable(ofs_code));

  a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
    ofs_force |-> (phase_code >= lo_r) && (phase_code <= hi_r));
endmodule

// File: tb/test_margin_phase_sweep.sv
`timescale 1ns/1ps
module test_margin_phase_sweep;
  localparam int NPH = 8, OW = 4, EW = 3, WN = 8, HALF = 2;
  localparam int PW = 3, DW = PW + OW + EW;
  localparam int OMAX = 15, EMAX = 7;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, abbrev = 1'b0;
  logic bit_valid = 1'b0, err_bit = 1'b0;
  logic [PW-1:0] rd_addr = '0, phase_code;
  logic [OW-1:0] ofs_code;
  logic ofs_force, done;
  logic [DW-1:0] rd_data;

  margin_phase_sweep #(.NPH(NPH), .OFS_W(OW), .ERR_W(EW), .WIN(WN), .ABBR_HALF(HALF)) i_margin_phase_sweep (
    .clk(clk), .rst(rst), .start(start), .abbrev(abbrev),
    .bit_valid(bit_valid), .err_bit(err_bit), .rd_addr(rd_addr),
    .phase_code(phase_code), .ofs_code(ofs_code), .ofs_force(ofs_force),
    .rd_data(rd_data), .done(done)
  );

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  int m_a [NPH], bad_a [NPH], e_a [NPH];
  int exp_m [NPH], exp_e [NPH], seen [NPH];
  int cur_best = 0;
  int mode = 2;              // 0 model, 1 junk, 2 quiet
  int idx = 0;
  bit bv_q = 1'b0;
  logic [PW+OW:0] last_key = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // error stream driven from the settings seen at the ports
  always @(negedge clk) begin
    logic [PW+OW:0] key;
    bit bv, e;
    int p;
    if (bv_q) idx++;
    key = {ofs_force, phase_code, ofs_code};
    if (key != last_key) idx = 0;
    last_key = key;
    p = int'(phase_code);
    case (mode)
      0: begin
        bv = ($urandom % 4) != 0;
        if (bad_a[p] != 0) e = idx < e_a[p];
        else               e = (int'(ofs_code) > m_a[p]) && (idx == 0);
        err_bit   = ofs_force && bv && e;
        bit_valid = bv;
      end
      1: begin
        bv = $urandom % 2;
        bit_valid = bv;
        err_bit   = $urandom % 2;
      end
      default: begin
        bv = 1'b0;
        bit_valid = 1'b0;
        err_bit   = 1'b0;
      end
    endcase
    bv_q = bv;
  end

  function automatic int pick_fn(input int lo, input int hi);
    int bm = -1, be = 1000, s = -1;
    for (int p = lo; p <= hi; p++)
      if (exp_m[p] > bm || (exp_m[p] == bm && exp_e[p] < be)) begin
        bm = exp_m[p]; be = exp_e[p];
      end
    for (int p = lo; p <= hi; p++) begin
      if (exp_m[p] == bm && exp_e[p] == be) begin
        if (s < 0) s = p;
      end else if (s >= 0) return s + (p - 1 - s) / 2;
    end
    return s + (hi - s) / 2;
  endfunction

  task automatic readback(input string req);
    for (int a = 0; a < NPH; a++) begin
      if (seen[a] != 0) begin
        rd_addr = PW'(a);
        @(negedge clk);
        chk(rd_data == {PW'(a), OW'(exp_m[a]), EW'(exp_e[a])}, req, $sformatf("entry %0d", a),
            int'(rd_data), int'({PW'(a), OW'(exp_m[a]), EW'(exp_e[a])}));
      end
    end
  endtask

  task automatic run_sweep(input bit ab, input bit mid_start, input string tag);
    int lo, hi, pick, cyc, prevp;
    bit stepok;
    lo = ab ? ((cur_best - HALF < 0) ? 0 : cur_best - HALF) : 0;
    hi = ab ? ((cur_best + HALF > NPH - 1) ? NPH - 1 : cur_best + HALF) : NPH - 1;
    for (int p = lo; p <= hi; p++) begin
      if (bad_a[p] != 0) begin
        exp_m[p] = 0;
        exp_e[p] = (e_a[p] > EMAX) ? EMAX : e_a[p];
      end else begin
        exp_m[p] = m_a[p];
        exp_e[p] = 0;
      end
      seen[p] = 1;
    end
    pick = pick_fn(lo, hi);
    mode = 0;
    @(negedge clk); start = 1'b1; abbrev = ab;
    @(negedge clk); start = 1'b0;
    chk(phase_code == PW'(lo) && ofs_code == OW'(OMAX) && ofs_force && !done,
        ab ? "R2 R10" : "R2", {tag, " start load"}, int'({phase_code, ofs_code}), (lo << OW) | OMAX);
    prevp = lo; cyc = 0; stepok = 1'b1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = mid_start && (cyc == 30);
      if (ofs_force && int'(phase_code) != prevp) begin
        if (int'(phase_code) != prevp + 1 || ofs_code != OW'(OMAX)) stepok = 1'b0;
        prevp = int'(phase_code);
      end
    end
    start = 1'b0;
    chk(cyc < 20000, "R9", {tag, " watchdog"}, cyc, 0);
    if (cyc >= 20000) return;
    chk(stepok && prevp == hi, "R6", {tag, " phase stepping"}, prevp, hi);
    chk(int'(phase_code) == pick, mid_start ? "R7 R8 R11" : "R7 R8", {tag, " chosen phase"},
        int'(phase_code), pick);
    chk(done && !ofs_force, "R9", {tag, " frozen flags"}, int'({done, ofs_force}), 2);
    cur_best = pick;
    readback(ab ? "R3 R4 R5 R10" : "R3 R4 R5");
  endtask

  task automatic set_good(input int v0, v1, v2, v3, v4, v5, v6, v7);
    m_a = '{v0, v1, v2, v3, v4, v5, v6, v7};
    bad_a = '{default: 0};
  endtask

  initial begin
    int hold;
    void'($urandom(32'd1357));
    for (int i = 0; i < NPH; i++) seen[i] = 0;
    repeat (4) @(negedge clk);
    chk(!done && !ofs_force && phase_code == '0, "R1", "during reset", int'({done, ofs_force, phase_code}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !ofs_force && phase_code == '0, "R1", "after reset", int'({done, ofs_force, phase_code}), 0);

    // tied best margin: first run 1..4, centre 2
    set_good(3, 9, 9, 9, 9, 2, 9, 9);
    run_sweep(1'b0, 1'b0, "tie");

    // every phase fails at code 0; saturation of 8 errors to 7; best run 3..4
    m_a = '{default: 0};
    bad_a = '{default: 1};
    e_a = '{8, 5, 8, 3, 3, 6, 8, 4};
    run_sweep(1'b0, 1'b0, "all bad R4");

    // maximum code clean at the last phase, stray start mid-sweep
    set_good(4, 5, 6, 7, 8, 9, 10, 15);
    run_sweep(1'b0, 1'b1, "top code");

    // inputs toggled while done
    hold = int'(phase_code);
    mode = 1;
    repeat (40) @(negedge clk);
    mode = 2;
    chk(int'(phase_code) == hold && done && !ofs_force, "R9", "junk while done", int'(phase_code), hold);
    readback("R9");

    // abbreviated rerun around 7: range 5..7, 0..4 retained
    set_good(1, 1, 1, 1, 1, 6, 11, 3);
    run_sweep(1'b1, 1'b0, "abbrev high");

    // best at phase 0, then abbreviated clamp 0..2
    set_good(12, 5, 4, 3, 2, 1, 0, 0);
    run_sweep(1'b0, 1'b0, "low best");
    set_good(2, 7, 7, 14, 14, 14, 14, 14);
    run_sweep(1'b1, 1'b0, "abbrev low");

    // random channels
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < NPH; p++) begin
        m_a[p]   = $urandom % 6;
        bad_a[p] = ($urandom % 4) == 0;
        e_a[p]   = 1 + ($urandom % 8);
      end
      run_sweep(r % 3 == 2, 1'b0, "random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    nchk++; nerr++;
    $display("FAIL R9 global watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule